// File: doc/BRIEF.md
# TDM Time-Slot Interchange with Message Channels

This block switches bytes between the channels of eight serial time-division streams. Every frame has 32 channel slots of 8 bits, and the bits are sent most significant bit first. Each input byte is captured into a double-banked data store. During the next frame, any output channel on any stream can read that byte. The switching delay is therefore exactly one frame for every connection.

The routing of each output channel is set by a connection store with two words. The byte word holds either a source address or a fixed byte to transmit. The 3-bit flag word holds three bits:
- a message flag;
- a control bit that is sent on a separate serial pin one slot early;
- a driver enable.

A host reaches all stores through a one-byte control register. This register picks the store and the stream. It also holds a global message-mode bit that forces every channel to transmit its byte word.

The frame position counts from the release of reset. The output side supplies a data bit and a driver-enable bit for each stream, and the pad ring builds the tristate from them.

Top module: `tdm_slot_switch`

## Requirements
- R1: The control register is reached with `cpu_reg_i`=1. Its bits are assigned as follows:
  - bits 2:0 select the stream;
  - bits 4:3 select the store (01 data, 10 byte word, 11 flag word, 00 none);
  - bit 6 is message mode;
  - bits 7 and 5 always read back as 0.
- R2: The data store is read-only from the host, and writes to it are ignored. A read returns the byte most recently captured for the selected stream and channel: the current frame's byte if that channel's slot has already ended, otherwise the previous frame's byte. With store select 00, reads return 0 and writes change nothing.
- R3: Byte words and flag words can be written and read back at the selected stream and channel `cpu_addr_i`. Flag-word bits 7:3 read as 0.
- R4: One frame is 256 clocks (32 slots × 8 bits), and the first frame starts at the first clock after reset is released internally. On the last bit of each slot, the input byte of every stream is stored, with the first bit of the slot as the MSB.
- R5: The byte word of a channel is read as a source address: bits 7:5 give the source stream and bits 4:0 give the source channel. When the flag-word bit 2 is 0 and message mode is off, the channel sends the byte that this source address received in the previous frame, MSB first.
- R6: When flag-word bit 2 is 1, the channel sends its byte word.
- R7: When message mode is off and `ode_i` is 1, `ser_oe_o[s]` equals flag-word bit 0 of the current channel.
- R8: When message mode is on and `ode_i` is 1, every channel on every stream sends its byte word with its driver enabled.
- R9: When `ode_i` is 0, all driver enables are 0, whatever the mode.
- R10: In bit position b of slot c, `cso_o` carries flag-word bit 1 of stream b, channel (c+1) mod 32. Slot 31 carries the bits for channel 0.
- R11: After reset, all flag words are 0 and the control register is 0. All driver enables are therefore off, and `cso_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ode_i | input | 1 | Global driver enable |
| ser_i | input | 8 | Serial input bit per stream |
| ser_o | output | 8 | Serial output bit per stream |
| ser_oe_o | output | 8 | Driver enable per stream for the current channel |
| cso_o | output | 1 | Serial control bit stream, one slot early |
| cpu_cs_i | input | 1 | Host access strobe (one clock per access) |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_reg_i | input | 1 | 1 = control register, 0 = selected store |
| cpu_addr_i | input | 5 | Channel within the selected stream |
| cpu_wdata_i | input | 8 | Write data |
| cpu_rdata_o | output | 8 | Read data (combinational) |

## Verification
The hardest case to reach is the host read of the data store. Which frame's byte it returns depends on where the frame counter stands relative to the channel being read. The stimulus keeps a running count of bit positions from reset and drives a known byte pattern on every stream in every slot. It then issues reads inside a chosen slot: one for a channel that has already passed, one for the channel in progress, and one for a later channel. The wrap of the early control bit from slot 31 to channel 0 is covered by a flag entry on channel 0, which is checked across frame boundaries.

// File: rtl/tsi_pkg.sv
`timescale 1ns/1ps
package tsi_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_W  = 3;

  typedef enum logic [1:0] {
    MSEL_NONE = 2'b00,
    MSEL_DATA = 2'b01,
    MSEL_CLO  = 2'b10,
    MSEL_CHI  = 2'b11
  } msel_e;

  typedef struct packed {
    logic msg;
    logic cso;
    logic oe;
  } chi_t;

  typedef struct packed {
    logic       mode;
    msel_e      msel;
    logic [2:0] stream;
  } ctrl_t;
endpackage

// File: rtl/tsi_timebase.sv
`timescale 1ns/1ps
module tsi_timebase #(
  parameter int CHANNELS = 32,
  localparam int CW = $clog2(CHANNELS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] ch_o,
  output logic [2:0]    bit_o,
  output logic          bank_o,
  output logic          slot_end_o,
  output logic          frame_end_o
);
  logic [CW+2:0] pos_q, pos_d;
  logic          bank_q, bank_d;

  assign ch_o        = pos_q[CW+2:3];
  assign bit_o       = pos_q[2:0];
  assign bank_o      = bank_q;
  assign slot_end_o  = &pos_q[2:0];
  assign frame_end_o = &pos_q;

  always_comb begin
    pos_d  = pos_q + 1'b1;
    bank_d = frame_end_o ? ~bank_q : bank_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      bank_q <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      bank_q <= bank_d;
    end
  end

  p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end_o |=> (pos_q == $past(pos_q) + 1'b1));
  p_bank_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_o |=> (bank_q != $past(bank_q)) && (pos_q == '0));
endmodule

// File: rtl/tsi_data_mem.sv
`timescale 1ns/1ps
module tsi_data_mem #(
  parameter int STREAMS  = 8,
  parameter int CHANNELS = 32,
  localparam int SW = $clog2(STREAMS),
  localparam int CW = $clog2(CHANNELS),
  localparam int AW = SW + CW,
  localparam int DEPTH = STREAMS * CHANNELS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STREAMS-1:0] ser_i,
  input  logic [CW-1:0]      ch_i,
  input  logic               slot_end_i,
  input  logic               wr_bank_i,
  input  logic [AW-1:0]      rd_addr_i [STREAMS],
  output logic [7:0]         rd_data_o [STREAMS],
  input  logic [SW-1:0]      cpu_stream_i,
  input  logic [CW-1:0]      cpu_ch_i,
  output logic [7:0]         cpu_data_o
);
  logic [6:0] sh_q [STREAMS];
  logic [6:0] sh_d [STREAMS];
  logic [7:0] mem_q [2][DEPTH];
  logic       cpu_bank;

  always_comb begin
    for (int s = 0; s < STREAMS; s++) sh_d[s] = {sh_q[s][5:0], ser_i[s]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STREAMS; s++) sh_q[s] <= '0;
    end else begin
      for (int s = 0; s < STREAMS; s++) sh_q[s] <= sh_d[s];
    end
  end

  // Storage without reset; written once per slot for every stream.
  always_ff @(posedge clk) begin
    if (slot_end_i) begin
      for (int s = 0; s < STREAMS; s++)
        mem_q[wr_bank_i][{SW'(s), ch_i}] <= {sh_q[s], ser_i[s]};
    end
  end

  // The output side always reads the bank completed in the previous frame.
  always_comb begin
    for (int s = 0; s < STREAMS; s++) rd_data_o[s] = mem_q[~wr_bank_i][rd_addr_i[s]];
  end

  // A channel whose slot has ended already holds this frame's byte.
  assign cpu_bank   = (ch_i > cpu_ch_i) ? wr_bank_i : ~wr_bank_i;
  assign cpu_data_o = mem_q[cpu_bank][{cpu_stream_i, cpu_ch_i}];

  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end_i |=> mem_q[$past(wr_bank_i)][$past({SW'(0), ch_i})]
                   == $past({sh_q[0], ser_i[0]}));
endmodule

// File: rtl/tsi_conn_mem.sv
`timescale 1ns/1ps
module tsi_conn_mem
  import tsi_pkg::*;
#(
  parameter int STREAMS  = 8,
  parameter int CHANNELS = 32,
  localparam int SW = $clog2(STREAMS),
  localparam int CW = $clog2(CHANNELS),
  localparam int DEPTH = STREAMS * CHANNELS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_i,
  input  logic          we_i,
  input  logic          reg_i,
  input  logic [CW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  input  logic [7:0]    dm_rdata_i,
  output logic [7:0]    rdata_o,
  output logic [SW-1:0] cpu_stream_o,
  input  logic [CW-1:0] ch_i,
  input  logic [2:0]    bit_i,
  output logic [7:0]    out_clo_o [STREAMS],
  output chi_t          out_chi_o [STREAMS],
  output logic          cso_o,
  output logic          mode_o
);
  ctrl_t         ctrl_q, ctrl_d;
  logic [7:0]    clo_q [DEPTH];
  chi_t          chi_q [DEPTH];
  logic          wr_reg, wr_clo, wr_chi;
  logic [SW+CW-1:0] idx;
  logic [CW-1:0] nxt_ch;

  assign idx          = {ctrl_q.stream[SW-1:0], addr_i};
  assign wr_reg       = cs_i & we_i & reg_i;
  assign wr_clo       = cs_i & we_i & ~reg_i & (ctrl_q.msel == MSEL_CLO);
  assign wr_chi       = cs_i & we_i & ~reg_i & (ctrl_q.msel == MSEL_CHI);
  assign cpu_stream_o = ctrl_q.stream[SW-1:0];
  assign mode_o       = ctrl_q.mode;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_reg) ctrl_d = '{mode: wdata_i[6], msel: msel_e'(wdata_i[4:3]), stream: wdata_i[2:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk) begin
    if (wr_clo) clo_q[idx] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) chi_q[i] <= '0;
    end else if (wr_chi) begin
      chi_q[idx] <= chi_t'(wdata_i[2:0]);
    end
  end

  always_comb begin
    rdata_o = '0;
    if (reg_i) begin
      rdata_o = {1'b0, ctrl_q.mode, 1'b0, ctrl_q.msel, ctrl_q.stream};
    end else begin
      unique case (ctrl_q.msel)
        MSEL_DATA: rdata_o = dm_rdata_i;
        MSEL_CLO:  rdata_o = clo_q[idx];
        MSEL_CHI:  rdata_o = {5'b0, chi_q[idx]};
        default:   rdata_o = '0;
      endcase
    end
  end

  always_comb begin
    for (int s = 0; s < STREAMS; s++) begin
      out_clo_o[s] = clo_q[{SW'(s), ch_i}];
      out_chi_o[s] = chi_q[{SW'(s), ch_i}];
    end
  end

  // Control bit of the next channel; bit position b carries stream b.
  assign nxt_ch = ch_i + 1'b1;
  generate
    if (STREAMS == 8) begin : g_cso_full
      assign cso_o = chi_q[{bit_i, nxt_ch}].cso;
    end else begin : g_cso_part
      assign cso_o = ({29'b0, bit_i} < STREAMS) ? chi_q[{bit_i[SW-1:0], nxt_ch}].cso : 1'b0;
    end
  endgenerate

  p_ctrl_pad_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_i && !we_i && reg_i) |-> (rdata_o[7] == 1'b0) && (rdata_o[5] == 1'b0));
  p_chi_pad_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_i && !we_i && !reg_i && ctrl_q.msel == MSEL_CHI) |-> (rdata_o[7:3] == 5'b0));
  p_chi_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_chi |=> (3'(chi_q[$past(idx)]) == $past(wdata_i[2:0])));
endmodule

// File: rtl/tdm_slot_switch.sv
`timescale 1ns/1ps
module tdm_slot_switch
  import tsi_pkg::*;
#(
  parameter int STREAMS  = 8,
  parameter int CHANNELS = 32,
  localparam int SW = $clog2(STREAMS),
  localparam int CW = $clog2(CHANNELS),
  localparam int AW = SW + CW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ode_i,
  input  logic [STREAMS-1:0] ser_i,
  output logic [STREAMS-1:0] ser_o,
  output logic [STREAMS-1:0] ser_oe_o,
  output logic               cso_o,
  input  logic               cpu_cs_i,
  input  logic               cpu_we_i,
  input  logic               cpu_reg_i,
  input  logic [CW-1:0]      cpu_addr_i,
  input  logic [7:0]         cpu_wdata_i,
  output logic [7:0]         cpu_rdata_o
);
  logic [1:0]    rs_q;
  logic          rst_int_n;
  logic [CW-1:0] ch;
  logic [2:0]    bitp;
  logic          bank, slot_end, frame_end, mode;
  logic [SW-1:0] cpu_stream;
  logic [7:0]    dm_cpu;
  logic [AW-1:0] rd_addr [STREAMS];
  logic [7:0]    rd_data [STREAMS];
  logic [7:0]    clo     [STREAMS];
  chi_t          chi     [STREAMS];

  // Reset asserts at once and leaves on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  tsi_timebase #(.CHANNELS(CHANNELS)) u_tb (
    .clk(clk), .rst_n(rst_int_n), .ch_o(ch), .bit_o(bitp), .bank_o(bank),
    .slot_end_o(slot_end), .frame_end_o(frame_end));

  tsi_data_mem #(.STREAMS(STREAMS), .CHANNELS(CHANNELS)) u_dm (
    .clk(clk), .rst_n(rst_int_n), .ser_i(ser_i), .ch_i(ch), .slot_end_i(slot_end),
    .wr_bank_i(bank), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .cpu_stream_i(cpu_stream), .cpu_ch_i(cpu_addr_i), .cpu_data_o(dm_cpu));

  tsi_conn_mem #(.STREAMS(STREAMS), .CHANNELS(CHANNELS)) u_cm (
    .clk(clk), .rst_n(rst_int_n), .cs_i(cpu_cs_i), .we_i(cpu_we_i), .reg_i(cpu_reg_i),
    .addr_i(cpu_addr_i), .wdata_i(cpu_wdata_i), .dm_rdata_i(dm_cpu),
    .rdata_o(cpu_rdata_o), .cpu_stream_o(cpu_stream), .ch_i(ch), .bit_i(bitp),
    .out_clo_o(clo), .out_chi_o(chi), .cso_o(cso_o), .mode_o(mode));

  generate
    for (genvar s = 0; s < STREAMS; s++) begin : g_out
      logic       use_msg;
      logic [7:0] tx_byte;
      assign rd_addr[s]  = clo[s][AW-1:0];
      assign use_msg     = mode | chi[s].msg;
      assign tx_byte     = use_msg ? clo[s] : rd_data[s];
      assign ser_o[s]    = tx_byte[~bitp];
      assign ser_oe_o[s] = ode_i & (mode | chi[s].oe);
    end
  endgenerate

  p_ode_off_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ode_i |-> (ser_oe_o == '0));
  p_msg_all_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ode_i && mode) |-> (&ser_oe_o));
  p_frame_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    frame_end |=> (ch == '0) && (bitp == 3'd0));
endmodule

// File: tb/tdm_slot_switch_bench.sv
`timescale 1ns/1ps
module tdm_slot_switch_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ode_i;
  logic [7:0] ser_i;
  logic [7:0] ser_o, ser_oe_o;
  logic       cso_o;
  logic       cpu_cs_i, cpu_we_i, cpu_reg_i;
  logic [4:0] cpu_addr_i;
  logic [7:0] cpu_wdata_i, cpu_rdata_o;

  always #10 clk = ~clk;

  tdm_slot_switch u_tdm_slot_switch (
    .clk(clk), .rst_n(rst_n), .ode_i(ode_i), .ser_i(ser_i), .ser_o(ser_o),
    .ser_oe_o(ser_oe_o), .cso_o(cso_o), .cpu_cs_i(cpu_cs_i), .cpu_we_i(cpu_we_i),
    .cpu_reg_i(cpu_reg_i), .cpu_addr_i(cpu_addr_i), .cpu_wdata_i(cpu_wdata_i),
    .cpu_rdata_o(cpu_rdata_o));

  int checks = 0;
  int fails  = 0;
  int pos    = 0;
  int rd_pos = 0;
  logic [7:0] rd_cap;
  bit   chk_en = 1'b0;
  bit   ode_v  = 1'b1;
  bit   mode_v = 1'b0;
  logic cs_v, we_v, reg_v;
  logic [4:0] addr_v;
  logic [7:0] wd_v;
  logic [7:0] m_clo [8][32];
  logic [2:0] m_chi [8][32];
  logic [7:0] acc [8];
  logic [7:0] cso_acc;

  // Entry: stream, channel, byte word, flag word {msg, cso, oe}.
  localparam logic [18:0] VEC [8] = '{
    {3'd0, 5'd0,  8'h23, 3'b001},
    {3'd1, 5'd31, 8'hFF, 3'b011},
    {3'd2, 5'd5,  8'hA5, 3'b101},
    {3'd7, 5'd10, 8'h00, 3'b001},
    {3'd3, 5'd0,  8'h3C, 3'b110},
    {3'd7, 5'd31, 8'h51, 3'b011},
    {3'd4, 5'd16, 8'h90, 3'b001},
    {3'd0, 5'd1,  8'h00, 3'b111}
  };

  function automatic logic [7:0] pat(int s, int c, int f);
    return 8'((s * 32 + c) * 7 + f * 13 + 1);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic slot_check();
    int f, ch, nc;
    logic [7:0] exp_b, c, exp_cso;
    bit exp_oe, msgsel;
    string req;
    f  = pos / 256;
    ch = (pos / 8) % 32;
    nc = (ch + 1) % 32;
    for (int s = 0; s < 8; s++) begin
      exp_oe = ode_v & (mode_v | m_chi[s][ch][0]);
      msgsel = mode_v | m_chi[s][ch][2];
      c      = m_clo[s][ch];
      exp_b  = msgsel ? c : pat(int'(c[7:5]), int'(c[4:0]), f - 1);
      req    = !ode_v ? "R9" : mode_v ? "R8" : m_chi[s][ch][2] ? "R6/R7" : "R5/R7";
      chk(ser_oe_o[s] == exp_oe, req, $sformatf("enable s%0d ch%0d", s, ch),
          int'(ser_oe_o[s]), int'(exp_oe));
      if (exp_oe)
        chk(acc[s] == exp_b, req, $sformatf("byte s%0d ch%0d", s, ch),
            int'(acc[s]), int'(exp_b));
    end
    for (int b = 0; b < 8; b++) exp_cso[b] = m_chi[b][nc][1];
    chk(cso_acc == exp_cso, "R10", $sformatf("control bits slot %0d", ch),
        int'(cso_acc), int'(exp_cso));
  endtask

  task automatic tick();
    int f, ch, bp;
    logic [7:0] pb;
    @(negedge clk);
    f  = pos / 256;
    ch = (pos / 8) % 32;
    bp = pos % 8;
    for (int s = 0; s < 8; s++) begin
      pb = pat(s, ch, f);
      ser_i[s] = pb[7 - bp];
    end
    cpu_cs_i = cs_v; cpu_we_i = we_v; cpu_reg_i = reg_v;
    cpu_addr_i = addr_v; cpu_wdata_i = wd_v; ode_i = ode_v;
    #1;
    rd_cap = cpu_rdata_o;
    rd_pos = pos;
    for (int s = 0; s < 8; s++) acc[s][7 - bp] = ser_o[s];
    cso_acc[bp] = cso_o;
    if (chk_en && bp == 7) slot_check();
    @(posedge clk);
    pos++;
  endtask

  task automatic cpu(bit rg, bit we, int addr, logic [7:0] wd);
    cs_v = 1'b1; we_v = we; reg_v = rg; addr_v = 5'(addr); wd_v = wd;
    tick();
    cs_v = 1'b0; we_v = 1'b0; reg_v = 1'b0;
    if (rg && we) mode_v = wd[6];
  endtask

  task automatic to_boundary();
    while (pos % 256 != 0) tick();
  endtask

  logic [7:0] e;
  int cur;

  initial begin
    cs_v = 0; we_v = 0; reg_v = 0; addr_v = 0; wd_v = 0;
    cpu_cs_i = 0; cpu_we_i = 0; cpu_reg_i = 0; cpu_addr_i = 0; cpu_wdata_i = 0;
    ode_i = 1'b1; ser_i = '0; rst_n = 1'b0;
    for (int s = 0; s < 8; s++)
      for (int c = 0; c < 32; c++) m_chi[s][c] = 3'b000;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(ser_oe_o == 8'h00, "R11", "enables in reset", int'(ser_oe_o), 0);
    chk(cso_o == 1'b0, "R11", "control bit in reset", int'(cso_o), 0);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk);
    pos = 0;

    cpu(1, 0, 0, 8'h00);
    chk(rd_cap == 8'h00, "R11", "control register after reset", int'(rd_cap), 0);
    cpu(1, 1, 0, 8'hFF);
    cpu(1, 0, 0, 8'h00);
    chk(rd_cap == 8'h5F, "R1", "control register pad bits", int'(rd_cap), 8'h5F);
    cpu(1, 1, 0, 8'h00);

    // Byte words for every channel: an address that differs per channel.
    for (int s = 0; s < 8; s++) begin
      cpu(1, 1, 0, 8'h10 | 8'(s));
      for (int c = 0; c < 32; c++) begin
        m_clo[s][c] = {3'(s) ^ 3'd5, 5'(c) ^ 5'd9};
        cpu(0, 1, c, m_clo[s][c]);
      end
    end

    // Vector table: program each entry, read both words back.
    for (int i = 0; i < 8; i++) begin
      int s, c;
      s = int'(VEC[i][18:16]);
      c = int'(VEC[i][15:11]);
      cpu(1, 1, 0, 8'h10 | 8'(s));
      cpu(0, 1, c, VEC[i][10:3]);
      m_clo[s][c] = VEC[i][10:3];
      cpu(0, 0, c, 8'h00);
      chk(rd_cap == VEC[i][10:3], "R3", $sformatf("byte word readback %0d", i),
          int'(rd_cap), int'(VEC[i][10:3]));
      cpu(1, 1, 0, 8'h18 | 8'(s));
      cpu(0, 1, c, {5'b11111, VEC[i][2:0]});
      m_chi[s][c] = VEC[i][2:0];
      cpu(0, 0, c, 8'h00);
      chk(rd_cap == {5'b0, VEC[i][2:0]}, "R3", $sformatf("flag word readback %0d", i),
          int'(rd_cap), int'({5'b0, VEC[i][2:0]}));
    end

    // Store select 00: reads zero, writes reach nothing.
    cpu(1, 1, 0, 8'h02);
    cpu(0, 1, 3, 8'hEE);
    cpu(0, 0, 3, 8'h00);
    chk(rd_cap == 8'h00, "R2", "store select 00 read", int'(rd_cap), 0);
    cpu(1, 1, 0, 8'h12);
    cpu(0, 0, 3, 8'h00);
    chk(rd_cap == m_clo[2][3], "R2", "byte word untouched by select 00",
        int'(rd_cap), int'(m_clo[2][3]));

    // Switching, messages, enables and early control bits over two frames.
    to_boundary();
    chk_en = 1'b1;
    repeat (512) tick();

    // Data-store reads relative to the current slot.
    while (pos % 256 != 80) tick();
    cpu(1, 1, 0, 8'h0B);
    foreach (VEC[k]) begin end
    for (int k = 0; k < 4; k++) begin
      int c;
      c = (k == 0) ? 5 : (k == 1) ? 10 : (k == 2) ? 20 : 5;
      if (k == 3) cpu(0, 1, 5, 8'h77);
      cpu(0, 0, c, 8'h00);
      cur = (rd_pos / 8) % 32;
      e = (cur > c) ? pat(3, c, rd_pos / 256) : pat(3, c, rd_pos / 256 - 1);
      chk(rd_cap == e, "R2", $sformatf("data store read ch%0d in slot %0d", c, cur),
          int'(rd_cap), int'(e));
    end

    // Global message mode.
    chk_en = 1'b0;
    cpu(1, 1, 0, 8'h40);
    to_boundary();
    chk_en = 1'b1;
    repeat (256) tick();

    // Drive enable pin low while in message mode.
    ode_v = 1'b0;
    repeat (256) tick();

    // Back to per-channel routing.
    chk_en = 1'b0;
    ode_v = 1'b1;
    cpu(1, 1, 0, 8'h00);
    to_boundary();
    chk_en = 1'b1;
    repeat (256) tick();
    chk_en = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(64'd200000 * 20);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule